// File: doc/BRIEF.md
# Resampling Nibble Playback Sequencer

This block walks a packed stream of 4-bit codes held in byte-wide memory and hands them one at a time to an external ADPCM decoder, at a rate set by a fractional step value. On every output tick the step is added to a phase accumulator. Each whole unit that overflows out of the fraction is one code to decode. The block then blends the two most recent decoded samples according to the remaining phase and scales the blend by an 8-bit volume. It produces one sample per tick.

The stream is addressed in nibbles. The lowest address bit selects the half of the byte, and the upper half is used first. A start address, an end address and a wrap (limit) address steer the walk. When the walk reaches the end, it either loops back to the start or stops and raises an end-of-stream flag. The decoder arithmetic sits outside the block. The block asks the decoder to reset its predictor when playback starts or loops, then feeds it nibbles through a request/acknowledge pair.

Top module: `nibble_resampler`

## Requirements
- R1: After reset, busy, eos, smp_out, smp_strobe, mem_rd, dec_req and dec_clear are all 0.
- R2: A go pulse starts playback on the next clock. The cycle after go is sampled, busy is 1, eos is 0, smp_out is 0 and dec_clear pulses. The phase is 0, the previous and current samples are 0, and the nibble address is start_addr with the half bit 0.
- R3: On each accepted tick, rate is added to the FRAC_W-bit phase. The carry above the fraction (0 to 4 with the default widths) is the number of nibbles decoded for that tick, and only the fraction is kept.
- R4: A nibble at an even nibble address makes one memory read, of the byte at nibble address divided by two, and uses bits 7:4 of that byte. A nibble at an odd address uses bits 3:0 of the byte already held and makes no read. mem_rdata must be valid in the cycle after mem_rd is high.
- R5: Before each nibble, a nibble address equal to limit_addr with half bit 0 becomes 0.
- R6: If the (possibly wrapped) address then equals end_addr with half bit 0 and rep_en is 1, the address reloads from start_addr. The previous and current samples clear, dec_clear pulses, and the nibble at start is decoded with no further end check.
- R7: If the address equals the end and rep_en is 0, eos becomes 1 and busy 0, and smp_out becomes 0. No fetch or decode follows until the next go.
- R8: After the decodes of a tick, smp_out = ((prev·(2^FRAC_W − phase) + cur·phase) >>> FRAC_W) · volume. The value is updated once, with a one-cycle smp_strobe, and held until the next update.
- R9: volume is an unsigned factor. A volume of 0 gives smp_out 0.
- R10: Ticks while not busy have no effect. No read or decoder request occurs and smp_out stays as it was.
- R11: The nibble address is 25 bits wide. Incrementing past byte 0xFFFFFF low nibble gives byte 0 high nibble.
- R12: dec_req stays high with a stable dec_nibble until dec_ack. Each acknowledged request moves prev to cur's old value and takes dec_sample as cur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start (or restart) playback pulse |
| rep_en | input | 1 | Loop to start at the end address |
| tick | input | 1 | Output sample tick |
| rate | input | RATE_W | Phase step per tick, FRAC_W fractional bits |
| start_addr | input | AW | First byte of the stream |
| end_addr | input | AW | Byte address where the stream ends |
| limit_addr | input | AW | Byte address that wraps to 0 |
| volume | input | VOL_W | Unsigned output scale |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | AW | Byte read address |
| mem_rdata | input | 8 | Read byte, valid the cycle after mem_rd |
| dec_clear | output | 1 | Reset the decoder predictor |
| dec_req | output | 1 | Nibble available for the decoder |
| dec_nibble | output | 4 | Nibble to decode |
| dec_ack | input | 1 | Decoder accepted the nibble, sample valid |
| dec_sample | input | SW | Decoded signed sample |
| smp_strobe | output | 1 | smp_out updated this cycle |
| smp_out | output | SW+VOL_W | Interpolated, scaled signed sample |
| eos | output | 1 | End of stream reached |
| busy | output | 1 | Playback active |

## Verification
The hardest case to reach is several decodes inside one tick that also cross the limit wrap, the end check or the 25-bit rollover. This mix exercises the odd/even fetch decisions and the loop reload together. Directed sessions place start, end and limit a few bytes apart and at the top of the address space, and use rates near the maximum so that one tick spans four nibbles. Random sessions then draw rate, volume, loop mode and sometimes a limit inside the stream. A bench model of memory, decoder and sequencer predicts each sample, flag and read count.

// File: rtl/nibseq_pkg.sv
package nibseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CHECK,
        ST_FETCH,
        ST_MEMW,
        ST_DEC,
        ST_OUT
    } seq_state_e;
endpackage

// File: rtl/nibseq_phase.sv
module nibseq_phase #(
    parameter int RATE_W = 18,
    parameter int FRAC_W = 16,
    parameter int SUM_W  = ((RATE_W > FRAC_W) ? RATE_W : FRAC_W) + 1,
    parameter int CNT_W  = SUM_W - FRAC_W
) (
    input  logic [FRAC_W-1:0] phase_q,
    input  logic [RATE_W-1:0] rate,
    output logic [FRAC_W-1:0] phase_next,
    output logic [CNT_W-1:0]  carry_cnt
);
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum        = SUM_W'(phase_q) + SUM_W'(rate);
        phase_next = sum[FRAC_W-1:0];
        carry_cnt  = sum[SUM_W-1:FRAC_W];
    end
endmodule

// File: rtl/nibseq_addr.sv
module nibseq_addr #(
    parameter int AW = 24
) (
    input  logic [AW:0]   naddr_q,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  logic [AW-1:0] limit_addr,
    output logic [AW:0]   eff_addr,
    output logic          hit_end,
    output logic [AW:0]   start_naddr,
    output logic [AW:0]   next_naddr
);
    always_comb begin
        eff_addr    = (naddr_q == {limit_addr, 1'b0}) ? '0 : naddr_q;
        hit_end     = (eff_addr == {end_addr, 1'b0});
        start_naddr = {start_addr, 1'b0};
        next_naddr  = naddr_q + 1'b1;
    end
endmodule

// File: rtl/nibseq_interp.sv
module nibseq_interp #(
    parameter int SW     = 16,
    parameter int FRAC_W = 16,
    parameter int VOL_W  = 8,
    parameter int OW     = SW + VOL_W
) (
    input  logic signed [SW-1:0] prev_smp,
    input  logic signed [SW-1:0] cur_smp,
    input  logic [FRAC_W-1:0]    phase,
    input  logic [VOL_W-1:0]     volume,
    output logic signed [OW-1:0] scaled
);
    localparam int PW = SW + FRAC_W + 2;

    logic signed [FRAC_W+1:0] w_prev;
    logic signed [FRAC_W+1:0] w_cur;
    logic signed [PW-1:0]     mix;
    logic signed [PW-1:0]     mix_sh;
    logic signed [SW-1:0]     blend;

    always_comb begin
        w_cur  = $signed({2'b00, phase});
        w_prev = $signed({2'b01, {FRAC_W{1'b0}}}) - w_cur;
        mix    = $signed({{(PW-SW){prev_smp[SW-1]}}, prev_smp}) *
                 $signed({{(PW-FRAC_W-2){w_prev[FRAC_W+1]}}, w_prev}) +
                 $signed({{(PW-SW){cur_smp[SW-1]}}, cur_smp}) *
                 $signed({{(PW-FRAC_W-2){w_cur[FRAC_W+1]}}, w_cur});
        mix_sh = mix >>> FRAC_W;
        blend  = mix_sh[SW-1:0];
        scaled = $signed({{(OW-SW){blend[SW-1]}}, blend}) *
                 $signed({{(OW-VOL_W){1'b0}}, volume});
    end
endmodule

// File: rtl/nibble_resampler.sv
module nibble_resampler #(
    parameter int AW     = 24,
    parameter int RATE_W = 18,
    parameter int FRAC_W = 16,
    parameter int SW     = 16,
    parameter int VOL_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic                     rep_en,
    input  logic                     tick,
    input  logic [RATE_W-1:0]        rate,
    input  logic [AW-1:0]            start_addr,
    input  logic [AW-1:0]            end_addr,
    input  logic [AW-1:0]            limit_addr,
    input  logic [VOL_W-1:0]         volume,
    output logic                     mem_rd,
    output logic [AW-1:0]            mem_addr,
    input  logic [7:0]               mem_rdata,
    output logic                     dec_clear,
    output logic                     dec_req,
    output logic [3:0]               dec_nibble,
    input  logic                     dec_ack,
    input  logic signed [SW-1:0]     dec_sample,
    output logic                     smp_strobe,
    output logic signed [SW+VOL_W-1:0] smp_out,
    output logic                     eos,
    output logic                     busy
);
    import nibseq_pkg::*;

    localparam int OW    = SW + VOL_W;
    localparam int SUM_W = ((RATE_W > FRAC_W) ? RATE_W : FRAC_W) + 1;
    localparam int CNT_W = SUM_W - FRAC_W;

    typedef struct packed {
        seq_state_e          st;
        logic [FRAC_W-1:0]   phase;
        logic [CNT_W-1:0]    left;
        logic [AW:0]         naddr;
        logic [7:0]          held;
        logic signed [SW-1:0] prev;
        logic signed [SW-1:0] cur;
        logic signed [OW-1:0] out;
        logic [3:0]          nib;
        logic                strobe;
        logic                eos;
        logic                busy;
        logic                clr;
        logic                rd;
        logic                req;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [FRAC_W-1:0]    phase_next;
    logic [CNT_W-1:0]     carry_cnt;
    logic [AW:0]          eff_addr;
    logic                 hit_end;
    logic [AW:0]          start_naddr;
    logic [AW:0]          next_naddr;
    logic signed [OW-1:0] scaled;

    nibseq_phase #(
        .RATE_W(RATE_W),
        .FRAC_W(FRAC_W),
        .SUM_W (SUM_W),
        .CNT_W (CNT_W)
    ) phase_i (
        .phase_q   (q.phase),
        .rate      (rate),
        .phase_next(phase_next),
        .carry_cnt (carry_cnt)
    );

    nibseq_addr #(
        .AW(AW)
    ) addr_i (
        .naddr_q    (q.naddr),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .limit_addr (limit_addr),
        .eff_addr   (eff_addr),
        .hit_end    (hit_end),
        .start_naddr(start_naddr),
        .next_naddr (next_naddr)
    );

    nibseq_interp #(
        .SW    (SW),
        .FRAC_W(FRAC_W),
        .VOL_W (VOL_W),
        .OW    (OW)
    ) interp_i (
        .prev_smp(q.prev),
        .cur_smp (q.cur),
        .phase   (q.phase),
        .volume  (volume),
        .scaled  (scaled)
    );

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        d.clr    = 1'b0;
        d.rd     = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                // ticks are ignored until playback starts
            end
            ST_WAIT: begin
                if (tick) begin
                    d.phase = phase_next;
                    d.left  = carry_cnt;
                    d.st    = (carry_cnt == '0) ? ST_OUT : ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (hit_end) begin
                    if (rep_en) begin
                        d.naddr = start_naddr;
                        d.prev  = '0;
                        d.cur   = '0;
                        d.clr   = 1'b1;
                        d.rd    = 1'b1;
                        d.st    = ST_FETCH;
                    end else begin
                        d.eos  = 1'b1;
                        d.busy = 1'b0;
                        d.out  = '0;
                        d.prev = '0;
                        d.cur  = '0;
                        d.st   = ST_IDLE;
                    end
                end else begin
                    d.naddr = eff_addr;
                    if (!eff_addr[0]) begin
                        d.rd = 1'b1;
                        d.st = ST_FETCH;
                    end else begin
                        d.nib = q.held[3:0];
                        d.req = 1'b1;
                        d.st  = ST_DEC;
                    end
                end
            end
            ST_FETCH: begin
                d.st = ST_MEMW;
            end
            ST_MEMW: begin
                d.held = mem_rdata;
                d.nib  = mem_rdata[7:4];
                d.req  = 1'b1;
                d.st   = ST_DEC;
            end
            ST_DEC: begin
                if (dec_ack) begin
                    d.req   = 1'b0;
                    d.prev  = q.cur;
                    d.cur   = dec_sample;
                    d.naddr = next_naddr;
                    d.left  = q.left - 1'b1;
                    d.st    = (q.left == CNT_W'(1)) ? ST_OUT : ST_CHECK;
                end
            end
            ST_OUT: begin
                d.out    = scaled;
                d.strobe = 1'b1;
                d.st     = ST_WAIT;
            end
            default: d.st = ST_IDLE;
        endcase

        if (go) begin
            d.st    = ST_WAIT;
            d.phase = '0;
            d.left  = '0;
            d.naddr = start_naddr;
            d.prev  = '0;
            d.cur   = '0;
            d.out   = '0;
            d.eos   = 1'b0;
            d.busy  = 1'b1;
            d.clr   = 1'b1;
            d.rd    = 1'b0;
            d.req   = 1'b0;
            d.strobe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_rd     = q.rd;
    assign mem_addr   = q.naddr[AW:1];
    assign dec_clear  = q.clr;
    assign dec_req    = q.req;
    assign dec_nibble = q.nib;
    assign smp_strobe = q.strobe;
    assign smp_out    = q.out;
    assign eos        = q.eos;
    assign busy       = q.busy;
endmodule

// File: rtl/nibble_resampler_chk.sv
module nibble_resampler_chk #(
    parameter int VOL_W = 8,
    parameter int OW    = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 go,
    input logic [VOL_W-1:0]     volume,
    input logic                 mem_rd,
    input logic                 dec_req,
    input logic                 dec_ack,
    input logic [3:0]           dec_nibble,
    input logic                 smp_strobe,
    input logic signed [OW-1:0] smp_out,
    input logic                 eos,
    input logic                 busy
);
    assert_go_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && !eos && smp_out == '0));

    assert_stop_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eos) |-> (!busy && smp_out == '0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !dec_req));

    assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && !dec_ack && !go) |=> (dec_req && $stable(dec_nibble)));

    assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_strobe && $past(volume) == '0) |-> smp_out == '0);

    assert_strobe_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_strobe |-> (busy && !eos));
endmodule

bind nibble_resampler nibble_resampler_chk #(
    .VOL_W(VOL_W),
    .OW   (SW + VOL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .volume    (volume),
    .mem_rd    (mem_rd),
    .dec_req   (dec_req),
    .dec_ack   (dec_ack),
    .dec_nibble(dec_nibble),
    .smp_strobe(smp_strobe),
    .smp_out   (smp_out),
    .eos       (eos),
    .busy      (busy)
);

// File: tb/nibble_resampler_tb_top.sv
module nibble_resampler_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               go = 1'b0;
    logic               rep_en = 1'b0;
    logic               tick = 1'b0;
    logic [17:0]        rate = '0;
    logic [23:0]        start_addr = '0;
    logic [23:0]        end_addr = '0;
    logic [23:0]        limit_addr = 24'hFFFFFF;
    logic [7:0]         volume = '0;
    logic               mem_rd;
    logic [23:0]        mem_addr;
    logic [7:0]         mem_rdata = '0;
    logic               dec_clear;
    logic               dec_req;
    logic [3:0]         dec_nibble;
    logic               dec_ack = 1'b0;
    logic signed [15:0] dec_sample = '0;
    logic               smp_strobe;
    logic signed [23:0] smp_out;
    logic               eos;
    logic               busy;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int rd_cnt = 0;
    int ack_cnt = 0;
    int bacc = 0;

    // bench-side model state
    logic [24:0] m_addr;
    int          m_phase, m_prev, m_cur, m_acc;
    logic [7:0]  m_byte;
    bit          m_busy, m_eos;
    longint      m_out;

    always #2 clk = ~clk;

    nibble_resampler dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .rep_en(rep_en), .tick(tick),
        .rate(rate), .start_addr(start_addr), .end_addr(end_addr),
        .limit_addr(limit_addr), .volume(volume), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dec_clear(dec_clear),
        .dec_req(dec_req), .dec_nibble(dec_nibble), .dec_ack(dec_ack),
        .dec_sample(dec_sample), .smp_strobe(smp_strobe), .smp_out(smp_out),
        .eos(eos), .busy(busy)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        int v;
        v = (int'(a[7:0]) * 37 + 11) ^ int'(a[10:3]);
        return v[7:0];
    endfunction

    function automatic int dec_step(input int acc, input logic [3:0] nib);
        int s, r;
        s = (nib < 8) ? int'(nib) : int'(nib) - 16;
        r = acc + s * 1500 + 7;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic longint interp(input int p, input int c, input int ph, input int vol);
        longint mix;
        mix = longint'(p) * (65536 - ph) + longint'(c) * ph;
        mix = mix >>> 16;
        return mix * vol;
    endfunction

    // memory: byte valid the cycle after the read strobe
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem_byte(mem_addr);
            rd_cnt <= rd_cnt + 1;
        end
    end

    // decoder: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (!rst_n) begin
            dec_ack <= 1'b0;
            bacc <= 0;
        end else if (dec_clear) begin
            bacc <= 0;
            dec_ack <= 1'b0;
        end else if (dec_req && !dec_ack) begin
            bacc <= dec_step(bacc, dec_nibble);
            dec_sample <= 16'(dec_step(bacc, dec_nibble));
            dec_ack <= 1'b1;
        end else begin
            if (dec_req && dec_ack) ack_cnt <= ack_cnt + 1;
            dec_ack <= 1'b0;
        end
    end

    task automatic chk(input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic model_tick(output int fetches, output int decs);
        longint sum;
        int cnt;
        logic [3:0] nib;
        fetches = 0;
        decs = 0;
        if (!m_busy) return;
        sum = longint'(m_phase) + longint'(rate);
        m_phase = int'(sum & 64'hFFFF);
        cnt = int'(sum >> 16);
        for (int i = 0; i < cnt; i++) begin
            if (m_addr == {limit_addr, 1'b0}) m_addr = '0;
            if (m_addr == {end_addr, 1'b0}) begin
                if (rep_en) begin
                    m_addr = {start_addr, 1'b0};
                    m_prev = 0; m_cur = 0; m_acc = 0;
                end else begin
                    m_busy = 0; m_eos = 1; m_out = 0;
                    return;
                end
            end
            if (!m_addr[0]) begin
                m_byte = mem_byte(m_addr[24:1]);
                nib = m_byte[7:4];
                fetches++;
            end else begin
                nib = m_byte[3:0];
            end
            m_acc = dec_step(m_acc, nib);
            m_prev = m_cur;
            m_cur = m_acc;
            m_addr = m_addr + 1'b1;
            decs++;
        end
        m_out = interp(m_prev, m_cur, m_phase, int'(volume));
    endtask

    task automatic play(input logic [23:0] s, input logic [23:0] e, input logic [23:0] l,
                        input logic [17:0] r, input logic [7:0] v, input bit rep);
        @(negedge clk);
        start_addr = s; end_addr = e; limit_addr = l; rate = r; volume = v; rep_en = rep;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk("R2 busy after go", busy, 1);
        chk("R2 eos after go", eos, 0);
        chk("R2 output after go", smp_out, 0);
        chk("R2 decoder clear", dec_clear, 1);
        m_addr = {s, 1'b0}; m_phase = 0; m_prev = 0; m_cur = 0; m_acc = 0;
        m_busy = 1; m_eos = 0; m_out = 0;
    endtask

    task automatic do_tick(input string tag);
        int rd0, ack0, ef, ed;
        longint prev_out;
        rd0 = rd_cnt; ack0 = ack_cnt; prev_out = smp_out;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (smp_strobe || !busy) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        model_tick(ef, ed);
        chk({tag, " R8 sample"}, smp_out, m_out);
        chk({tag, " R7 busy"}, busy, m_busy);
        chk({tag, " R7 eos"}, eos, m_eos);
        chk({tag, " R4 reads"}, rd_cnt - rd0, ef);
        chk({tag, " R3 R12 decodes"}, ack_cnt - ack0, ed);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_0C0A;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 eos", eos, 0);
        chk("R1 out", smp_out, 0);
        chk("R1 mem_rd", mem_rd, 0);
        chk("R1 dec_req", dec_req, 0);
        chk("R1 strobe", smp_strobe, 0);

        // R10 ticks while idle
        m_busy = 0; m_eos = 0; m_out = 0;
        begin
            int rd0;
            rd0 = rd_cnt;
            repeat (3) begin
                @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
            end
            repeat (3) @(negedge clk);
            chk("R10 idle reads", rd_cnt - rd0, 0);
            chk("R10 idle out", smp_out, 0);
            chk("R10 idle busy", busy, 0);
        end

        // R4 R8: one nibble per tick, then R7 stop
        play(24'h10, 24'h13, 24'hFFFFFF, 18'h10000, 8'd255, 0);
        for (int i = 0; i < 8; i++) do_tick("unit rate");
        chk("R7 stopped", eos, 1);
        do_tick("R10 after stop");

        // R3 R8: fractional rate, zero or one decode per tick
        play(24'h20, 24'h28, 24'hFFFFFF, 18'h06000, 8'd100, 0);
        for (int i = 0; i < 10; i++) do_tick("frac rate");

        // R3: near max rate, four decodes per tick
        play(24'h30, 24'h60, 24'hFFFFFF, 18'h3FFFF, 8'd77, 0);
        for (int i = 0; i < 6; i++) do_tick("max rate");

        // R5: limit wraps to zero
        play(24'h30, 24'h05, 24'h32, 18'h10000, 8'd200, 0);
        for (int i = 0; i < 16; i++) do_tick("R5 limit");
        chk("R5 end after wrap", eos, 1);

        // R6: repeat loop
        play(24'h40, 24'h42, 24'hFFFFFF, 18'h18000, 8'd33, 1);
        for (int i = 0; i < 12; i++) do_tick("R6 loop");
        chk("R6 still busy", busy, 1);

        // R11: top of address space rolls over
        play(24'hFFFFFF, 24'h000002, 24'h800000, 18'h10000, 8'd150, 0);
        for (int i = 0; i < 8; i++) do_tick("R11 rollover");
        chk("R11 end reached", eos, 1);

        // R9: mute and unit volume
        play(24'h50, 24'h58, 24'hFFFFFF, 18'h0C000, 8'd0, 0);
        for (int i = 0; i < 4; i++) do_tick("R9 mute");
        volume = 8'd1;
        for (int i = 0; i < 3; i++) do_tick("R9 unit vol");

        // random sessions
        for (int n = 0; n < 24; n++) begin
            logic [23:0] s, e, l;
            int len;
            s = 24'($urandom_range(16, 96));
            len = $urandom_range(1, 8);
            e = s + 24'(len);
            l = ($urandom_range(0, 2) == 0) ? s + 24'($urandom_range(0, len)) : 24'hFFFFFF;
            play(s, e, l, 18'($urandom_range(0, 18'h3FFFF)), 8'($urandom_range(0, 255)),
                 bit'($urandom_range(0, 1)));
            for (int i = 0; i < 12; i++) do_tick("random R3 R5 R6");
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule